// File: doc/BRIEF.md
# Burst-Splitting Bus Master Sequencer

This block moves a block of data of programmable length between several internal channels and a 32-bit external bus, in either direction. A channel raises a request and receives a one-cycle acknowledge. In the cycle after that, it presents a start address, a byte length and a direction. For writes the channel then streams every data word into an internal staging FIFO, and only after that does the sequencer ask for the bus. Reads are forwarded to the channel one word per acknowledged beat.

The sequencer splits the transfer into bus transactions by itself. It issues a 4-beat burst (16 bytes) when the current address sits on a 16-byte line boundary and at least a full line remains. Otherwise it issues a single-beat transaction. It keeps requesting the bus until the whole length has moved. If a target terminates a beat with a transfer-error acknowledge, the sequencer abandons the rest of the transfer and reports completion with an error. It also sets a sticky error flag, logs the first faulting address, and marks the requesting channel in an error vector. That vector drives a maskable interrupt.

Top module: `burst_xfer_seq`

## Requirements
- R1: When the sequencer is idle, the lowest-numbered requesting channel receives a one-hot acknowledge, one cycle long, on the clock after the request is seen. The descriptor is taken on the first cycle with desc_valid_i high after that.
- R2: For a write, wr_ready_o stays high until length/4 words have been accepted. bus_req_o rises only after that, and the staging FIFO never overflows. The write length must not exceed 4 × FIFO depth.
- R3: The sequencer raises bus_req_o again after each transaction until the full length has moved. bus_busy_o marks the data phase. bus_addr_o advances by 4 on every acknowledged beat.
- R4: A transaction is a 4-beat burst (bus_burst_o=1) when bus_addr_o[3:0]==0 and at least 16 bytes remain. Otherwise it is a single beat (bus_burst_o=0). bus_burst_o is valid whenever bus_req_o is high.
- R5: Read data is presented on rd_data_o with rd_valid_o one cycle after each acknowledged beat. Write beats drive bus_wdata_o with the staged words in load order.
- R6: done_o is a one-cycle pulse carrying done_id_o. For reads it coincides with the last rd_valid_o. For writes it comes on the cycle after the final acknowledge. A zero length completes without any bus request.
- R7: A bus_tea_i during a data phase ends the transfer. done_o follows on the next cycle with done_err_o=1, and tea_flag_o is set.
- R8: tea_addr_o captures bus_addr_o of the first faulting beat. It holds that value through later errors until tea_clr_i, which also clears tea_flag_o.
- R9: A transfer error sets the bit of the active channel in chan_err_o. irq_o is the OR of the chan_err_o bits whose irq_mask_i bit is 0. tea_clr_i clears the vector.
- R10: The two low bits of the start address and of the length are ignored, so transfers are whole words on word boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_req_i | input | NCH | Per-channel service request |
| chan_ack_o | output | NCH | One-hot acknowledge pulse |
| desc_valid_i | input | 1 | Descriptor strobe |
| desc_addr_i | input | AW | Start byte address |
| desc_len_i | input | LW | Length in bytes |
| desc_write_i | input | 1 | 1 = write to bus, 0 = read from bus |
| wr_valid_i | input | 1 | Write word valid |
| wr_data_i | input | DW | Write word |
| wr_ready_o | output | 1 | Staging FIFO accepting words |
| rd_valid_o | output | 1 | Read word valid |
| rd_data_o | output | DW | Read word |
| done_o | output | 1 | Transfer complete pulse |
| done_err_o | output | 1 | Completion ended by transfer error |
| done_id_o | output | CHW | Channel that completed |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_busy_o | output | 1 | Data phase in progress |
| bus_addr_o | output | AW | Current beat address |
| bus_burst_o | output | 1 | 4-beat burst transaction |
| bus_we_o | output | 1 | Write transaction |
| bus_wdata_o | output | DW | Write beat data |
| bus_rdata_i | input | DW | Read beat data |
| bus_ack_i | input | 1 | Beat acknowledge |
| bus_tea_i | input | 1 | Transfer error acknowledge |
| tea_flag_o | output | 1 | Sticky transfer-error flag |
| tea_addr_o | output | AW | Logged faulting address |
| tea_clr_i | input | 1 | Clear flag, log and channel errors |
| irq_mask_i | input | NCH | Per-channel interrupt mask |
| chan_err_o | output | NCH | Per-channel error bits |
| irq_o | output | 1 | Interrupt |

## Verification
The first pattern is a line-aligned read whose length ends in a partial line. It shows that the block moves from bursts to single beats exactly when less than a line remains. An unaligned write shows that single beats are used until the address reaches a line boundary, and that burst selection depends on alignment as well as length. A read with acknowledge wait states shows that data, address and completion follow acknowledged beats rather than cycles. Error runs inject a fault in the middle of a burst, then a second masked fault on another channel. These show abandonment, first-address logging and the per-channel interrupt masking. Two channels requesting at once, a zero length and a length with stray low bits cover arbitration order and the edge lengths.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  localparam int BEAT_BYTES  = 4;
  localparam int BURST_BEATS = 4;
  localparam int LINE_BYTES  = BEAT_BYTES * BURST_BEATS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_LOAD,
    ST_REQ,
    ST_XFER,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/bxs_arb.sv
module bxs_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] gnt_o,
  output logic [CHW-1:0] id_o,
  output logic           any_o
);
  // fixed priority, lowest index wins
  always_comb begin
    gnt_o = '0;
    id_o  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        id_o     = CHW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/bxs_fifo.sv
module bxs_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o = mem_q[rp_q];
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CW'(DEPTH));

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/bxs_errlog.sv
module bxs_errlog #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tea_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [CHW-1:0] ch_i,
  input  logic           clr_i,
  input  logic [NCH-1:0] mask_i,
  output logic           flag_o,
  output logic [AW-1:0]  addr_o,
  output logic [NCH-1:0] err_o,
  output logic           irq_o
);
  logic          flag_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (tea_i)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      // keep the first fault until cleared
      if (tea_i && (!flag_q || clr_i)) addr_q <= addr_i;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_err
    logic err_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         err_q <= 1'b0;
      else if (tea_i && ch_i == CHW'(i))   err_q <= 1'b1;
      else if (clr_i)                      err_q <= 1'b0;
    end
    assign err_o[i] = err_q;
  end

  assign flag_o = flag_q;
  assign addr_o = addr_q;
  assign irq_o  = |(err_o & ~mask_i);

  p_log_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> (flag_q && $stable(addr_q)));
  p_err_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_o) |-> flag_q);
endmodule

// File: rtl/burst_xfer_seq.sv
module burst_xfer_seq
  import bxs_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LW    = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int WW  = LW - 2,
  localparam int LB  = $clog2(LINE_BYTES),
  localparam int FCW = ((FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] chan_req_i,
  output logic [NCH-1:0] chan_ack_o,
  input  logic           desc_valid_i,
  input  logic [AW-1:0]  desc_addr_i,
  input  logic [LW-1:0]  desc_len_i,
  input  logic           desc_write_i,
  input  logic           wr_valid_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic           wr_ready_o,
  output logic           rd_valid_o,
  output logic [DW-1:0]  rd_data_o,
  output logic           done_o,
  output logic           done_err_o,
  output logic [CHW-1:0] done_id_o,
  output logic           bus_req_o,
  input  logic           bus_gnt_i,
  output logic           bus_busy_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic           bus_burst_o,
  output logic           bus_we_o,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic [DW-1:0]  bus_rdata_i,
  input  logic           bus_ack_i,
  input  logic           bus_tea_i,
  output logic           tea_flag_o,
  output logic [AW-1:0]  tea_addr_o,
  input  logic           tea_clr_i,
  input  logic [NCH-1:0] irq_mask_i,
  output logic [NCH-1:0] chan_err_o,
  output logic           irq_o
);
  seq_st_e        state_q;
  logic [NCH-1:0] ack_q;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  addr_q;
  logic [WW-1:0]  rem_q, beats_q, load_q;
  logic           burst_q, we_q, derr_q;
  logic           rd_valid_q;
  logic [DW-1:0]  rd_data_q;

  logic [NCH-1:0] arb_gnt;
  logic [CHW-1:0] arb_id;
  logic           arb_any;

  logic           burst_ok;
  logic           beat_ok, tea_evt;
  logic           f_push, f_pop, f_flush, f_full;
  logic [FCW-1:0] f_cnt;
  logic [WW-1:0]  desc_words;

  bxs_arb #(.NCH(NCH)) u_arb (
    .req_i (chan_req_i),
    .gnt_o (arb_gnt),
    .id_o  (arb_id),
    .any_o (arb_any)
  );

  assign burst_ok   = (addr_q[LB-1:0] == '0) && (rem_q >= WW'(BURST_BEATS));
  assign tea_evt    = (state_q == ST_XFER) && bus_tea_i;
  assign beat_ok    = (state_q == ST_XFER) && bus_ack_i && !bus_tea_i;
  assign desc_words = desc_len_i[LW-1:2];

  assign f_push  = (state_q == ST_LOAD) && wr_valid_i;
  assign f_pop   = beat_ok && we_q;
  assign f_flush = tea_evt;

  bxs_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (f_push),
    .din_i   (wr_data_i),
    .pop_i   (f_pop),
    .flush_i (f_flush),
    .dout_o  (bus_wdata_o),
    .cnt_o   (f_cnt),
    .full_o  (f_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ack_q   <= '0;
      ch_q    <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      beats_q <= '0;
      load_q  <= '0;
      burst_q <= 1'b0;
      we_q    <= 1'b0;
      derr_q  <= 1'b0;
    end else begin
      ack_q <= '0;
      unique case (state_q)
        ST_IDLE: if (arb_any) begin
          ack_q   <= arb_gnt;
          ch_q    <= arb_id;
          state_q <= ST_DESC;
        end
        ST_DESC: if (desc_valid_i) begin
          addr_q <= {desc_addr_i[AW-1:2], 2'b00};
          rem_q  <= desc_words;
          we_q   <= desc_write_i;
          load_q <= '0;
          derr_q <= 1'b0;
          if (desc_words == '0)  state_q <= ST_DONE;
          else if (desc_write_i) state_q <= ST_LOAD;
          else                   state_q <= ST_REQ;
        end
        ST_LOAD: if (wr_valid_i) begin
          load_q <= load_q + 1'b1;
          if (load_q + 1'b1 == rem_q) state_q <= ST_REQ;
        end
        ST_REQ: if (bus_gnt_i) begin
          burst_q <= burst_ok;
          beats_q <= burst_ok ? WW'(BURST_BEATS) : WW'(1);
          state_q <= ST_XFER;
        end
        ST_XFER: begin
          if (bus_tea_i) begin
            derr_q  <= 1'b1;
            state_q <= ST_DONE;
          end else if (bus_ack_i) begin
            addr_q  <= addr_q + AW'(BEAT_BYTES);
            rem_q   <= rem_q - 1'b1;
            beats_q <= beats_q - 1'b1;
            if (rem_q == WW'(1))        state_q <= ST_DONE;
            else if (beats_q == WW'(1)) state_q <= ST_REQ;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= beat_ok && !we_q;
      if (beat_ok && !we_q) rd_data_q <= bus_rdata_i;
    end
  end

  bxs_errlog #(.NCH(NCH), .AW(AW)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tea_i  (tea_evt),
    .addr_i (addr_q),
    .ch_i   (ch_q),
    .clr_i  (tea_clr_i),
    .mask_i (irq_mask_i),
    .flag_o (tea_flag_o),
    .addr_o (tea_addr_o),
    .err_o  (chan_err_o),
    .irq_o  (irq_o)
  );

  assign chan_ack_o  = ack_q;
  assign wr_ready_o  = (state_q == ST_LOAD);
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign done_o      = (state_q == ST_DONE);
  assign done_err_o  = (state_q == ST_DONE) && derr_q;
  assign done_id_o   = ch_q;
  assign bus_req_o   = (state_q == ST_REQ);
  assign bus_busy_o  = (state_q == ST_XFER);
  assign bus_addr_o  = addr_q;
  assign bus_burst_o = (state_q == ST_XFER) ? burst_q : burst_ok;
  assign bus_we_o    = we_q;

  p_ack_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_ack_o));
  p_staged_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && we_q) |-> (WW'(f_cnt) == rem_q));
  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_ok && rem_q != WW'(1)) |=> (addr_q == $past(addr_q) + AW'(BEAT_BYTES)));
  p_beats_fit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER) |-> (beats_q <= rem_q && beats_q != '0));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_tea_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tea_evt |=> (done_o && done_err_o && tea_flag_o));
  p_fifo_room_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) |-> !f_full || !wr_valid_i);
endmodule

// File: tb/tb_burst_xfer_seq.sv
`timescale 1ns/1ps
module tb_burst_xfer_seq;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int LW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NCH-1:0] chan_req = '0, chan_ack;
  logic desc_valid = 1'b0, desc_write = 1'b0;
  logic [AW-1:0] desc_addr = '0;
  logic [LW-1:0] desc_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic rd_valid, done, done_err;
  logic [DW-1:0] rd_data;
  logic [1:0] done_id;
  logic bus_req, bus_gnt = 1'b0, bus_busy, bus_burst, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_ack = 1'b0, bus_tea = 1'b0;
  logic tea_flag, tea_clr = 1'b0, irq;
  logic [AW-1:0] tea_addr;
  logic [NCH-1:0] irq_mask = '0, chan_err;

  burst_xfer_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .chan_req_i(chan_req), .chan_ack_o(chan_ack),
    .desc_valid_i(desc_valid), .desc_addr_i(desc_addr), .desc_len_i(desc_len),
    .desc_write_i(desc_write),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .done_o(done), .done_err_o(done_err), .done_id_o(done_id),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_busy_o(bus_busy),
    .bus_addr_o(bus_addr), .bus_burst_o(bus_burst), .bus_we_o(bus_we),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_ack_i(bus_ack), .bus_tea_i(bus_tea),
    .tea_flag_o(tea_flag), .tea_addr_o(tea_addr), .tea_clr_i(tea_clr),
    .irq_mask_i(irq_mask), .chan_err_o(chan_err), .irq_o(irq)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(input string rq, input string nm,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", rq, nm, act, exp, $time);
    end
  endtask

  // ---------------- bus target model ----------------
  int  gnt_delay = 1, gcnt = 0;
  bit  wait_en = 0, tog = 0;
  bit  tea_armed = 0;
  logic [AW-1:0] tea_at = '0;
  int  n_burst = 0, n_single = 0;

  assign bus_rdata = ~bus_addr ^ 32'h5a5a_0000;

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 0; bus_ack = 0; bus_tea = 0; gcnt = 0;
    end else begin
      if (bus_req && !bus_gnt) begin
        if (gcnt >= gnt_delay) begin
          bus_gnt = 1; gcnt = 0;
          if (bus_burst) n_burst++; else n_single++;
        end else gcnt++;
      end else bus_gnt = 0;
      tog = ~tog;
      bus_tea = 0;
      bus_ack = 0;
      if (bus_busy) begin
        if (tea_armed && bus_addr == tea_at) begin
          bus_tea = 1; tea_armed = 0;
        end else bus_ack = wait_en ? tog : 1'b1;
      end
    end
  end

  // ---------------- reference model ----------------
  int m_st, m_ch, m_rem, m_beats, m_loaded;
  logic [NCH-1:0] m_ack, m_err;
  logic [31:0] m_addr, m_rdd, m_taddr;
  bit m_burst, m_we, m_rdv, m_derr, m_flag;
  logic [31:0] wq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ch = 0; m_rem = 0; m_beats = 0; m_loaded = 0;
      m_ack = '0; m_err = '0; m_addr = '0; m_rdd = '0; m_taddr = '0;
      m_burst = 0; m_we = 0; m_rdv = 0; m_derr = 0; m_flag = 0;
      wq.delete();
    end else begin
      bit tea_e, nrdv;
      tea_e = (m_st == 4) && bus_tea;
      nrdv = (m_st == 4) && bus_ack && !bus_tea && !m_we;
      if (nrdv) m_rdd = bus_rdata;
      m_rdv = nrdv;
      if (tea_e) begin
        if (!m_flag || tea_clr) m_taddr = m_addr;
        m_flag = 1;
      end else if (tea_clr) m_flag = 0;
      if (tea_clr) for (int i = 0; i < NCH; i++) m_err[i] = tea_e && (i == m_ch);
      else if (tea_e) m_err[m_ch] = 1'b1;
      m_ack = '0;
      case (m_st)
        0: if (chan_req != 0) begin
          for (int i = NCH - 1; i >= 0; i--) if (chan_req[i]) m_ch = i;
          m_ack[m_ch] = 1'b1;
          m_st = 1;
        end
        1: if (desc_valid) begin
          m_addr = {desc_addr[31:2], 2'b00};
          m_rem = int'(desc_len) / 4;
          m_we = desc_write; m_loaded = 0; m_derr = 0;
          m_st = (m_rem == 0) ? 5 : (m_we ? 2 : 3);
        end
        2: if (wr_valid) begin
          wq.push_back(wr_data); m_loaded++;
          if (m_loaded == m_rem) m_st = 3;
        end
        3: if (bus_gnt) begin
          m_burst = (m_addr % 16 == 0) && (m_rem >= 4);
          m_beats = m_burst ? 4 : 1;
          m_st = 4;
        end
        4: if (bus_tea) begin
          wq.delete(); m_derr = 1; m_st = 5;
        end else if (bus_ack) begin
          if (m_we) void'(wq.pop_front());
          m_addr += 4; m_rem--; m_beats--;
          if (m_rem == 0) m_st = 5;
          else if (m_beats == 0) m_st = 3;
        end
        default: m_st = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R1", "chan_ack", 32'(chan_ack), 32'(m_ack));
      chk("R2", "wr_ready", 32'(wr_ready), 32'(m_st == 2));
      chk("R3", "bus_req", 32'(bus_req), 32'(m_st == 3));
      chk("R3", "bus_busy", 32'(bus_busy), 32'(m_st == 4));
      if (m_st == 3 || m_st == 4) begin
        chk("R3", "bus_addr", bus_addr, m_addr);
        chk("R4", "bus_burst", 32'(bus_burst),
            32'(m_st == 4 ? m_burst : ((m_addr % 16 == 0) && (m_rem >= 4))));
        chk("R3", "bus_we", 32'(bus_we), 32'(m_we));
      end
      if (m_st == 4 && m_we && wq.size() > 0) chk("R5", "bus_wdata", bus_wdata, wq[0]);
      chk("R5", "rd_valid", 32'(rd_valid), 32'(m_rdv));
      if (m_rdv) chk("R5", "rd_data", rd_data, m_rdd);
      chk("R6", "done", 32'(done), 32'(m_st == 5));
      if (m_st == 5) begin
        chk("R6", "done_id", 32'(done_id), 32'(m_ch));
        chk("R7", "done_err", 32'(done_err), 32'(m_derr));
      end
      chk("R7", "tea_flag", 32'(tea_flag), 32'(m_flag));
      chk("R8", "tea_addr", tea_addr, m_taddr);
      chk("R9", "chan_err", 32'(chan_err), 32'(m_err));
      chk("R9", "irq", 32'(irq), 32'(|(m_err & ~irq_mask)));
    end
  end

  // ---------------- observation ----------------
  logic [31:0] rdq[$];
  int ack_order[$];
  always @(negedge clk) begin
    if (rst_n && chan_ack != 0)
      for (int i = 0; i < NCH; i++) if (chan_ack[i]) ack_order.push_back(i);
  end
  always @(posedge clk) begin
    #1;
    if (rst_n && rd_valid) rdq.push_back(rd_data);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic xfer(input int ch, input logic [31:0] addr, input int len,
                      input bit we, output bit err);
    int words;
    words = len / 4;
    @(negedge clk);
    chan_req[ch] = 1'b1;
    do @(negedge clk); while (!chan_ack[ch]);
    chan_req[ch] = 1'b0;
    desc_valid = 1; desc_addr = addr; desc_len = LW'(len); desc_write = we;
    @(negedge clk);
    desc_valid = 0;
    if (we && words > 0) begin
      int i;
      i = 0;
      while (i < words) begin
        if (wr_ready) begin
          wr_valid = 1; wr_data = 32'hc0de_0000 + addr + 32'(i);
          i++;
        end else wr_valid = 0;
        @(negedge clk);
      end
      wr_valid = 0;
    end
    while (!(done && done_id == 2'(ch))) @(negedge clk);
    err = done_err;
  endtask

  initial begin
    bit e1, e2;
    int b0, s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset ack", 32'(chan_ack), 0);
    chk("R3", "reset bus_req", 32'(bus_req), 0);
    chk("R6", "reset done", 32'(done), 0);
    chk("R9", "reset irq", 32'(irq), 0);

    // aligned read with partial tail
    rdq.delete(); n_burst = 0; n_single = 0;
    xfer(0, 32'h100, 40, 0, e1);
    @(negedge clk);
    chk("R4", "read bursts", 32'(n_burst), 2);
    chk("R4", "read singles", 32'(n_single), 2);
    chk("R5", "read beats", 32'(rdq.size()), 10);
    for (int k = 0; k < 10 && k < rdq.size(); k++)
      chk("R5", "read word", rdq[k], ~(32'h100 + 32'(4 * k)) ^ 32'h5a5a_0000);
    chk("R6", "read no err", 32'(e1), 0);

    // unaligned write
    n_burst = 0; n_single = 0; gnt_delay = 3;
    xfer(2, 32'h204, 44, 1, e1);
    @(negedge clk);
    chk("R4", "write singles", 32'(n_single), 3);
    chk("R4", "write bursts", 32'(n_burst), 2);

    // read with wait states
    n_burst = 0; n_single = 0; wait_en = 1; gnt_delay = 0;
    xfer(3, 32'h600, 20, 0, e1);
    wait_en = 0;
    chk("R4", "wait bursts", 32'(n_burst), 1);
    chk("R3", "wait singles", 32'(n_single), 1);

    // fault mid-burst, unmasked
    tea_armed = 1; tea_at = 32'h314;
    xfer(1, 32'h300, 32, 0, e1);
    @(negedge clk);
    chk("R7", "tea done_err", 32'(e1), 1);
    chk("R8", "tea log", tea_addr, 32'h314);
    chk("R9", "tea chan_err", 32'(chan_err), 32'b0010);
    chk("R9", "tea irq", 32'(irq), 1);

    // second fault, masked channel
    irq_mask = 4'b0100;
    tea_armed = 1; tea_at = 32'h404;
    xfer(2, 32'h400, 8, 1, e2);
    @(negedge clk);
    chk("R7", "tea2 done_err", 32'(e2), 1);
    chk("R8", "log holds first", tea_addr, 32'h314);
    chk("R9", "chan_err two", 32'(chan_err), 32'b0110);
    irq_mask = 4'b0110;
    @(negedge clk);
    chk("R9", "all masked irq", 32'(irq), 0);
    tea_clr = 1;
    @(negedge clk);
    tea_clr = 0;
    irq_mask = '0;
    @(negedge clk);
    chk("R8", "cleared flag", 32'(tea_flag), 0);
    chk("R9", "cleared err", 32'(chan_err), 0);

    // simultaneous requests
    ack_order.delete();
    fork
      xfer(3, 32'h700, 8, 0, e1);
      xfer(1, 32'h800, 16, 1, e2);
    join
    chk("R1", "ack first", 32'(ack_order.size() > 0 ? ack_order[0] : -1), 1);
    chk("R1", "ack second", 32'(ack_order.size() > 1 ? ack_order[1] : -1), 3);

    // zero length and stray low bits
    b0 = n_burst; s0 = n_single;
    xfer(0, 32'h900, 0, 0, e1);
    @(negedge clk);
    chk("R6", "zero len no bus", 32'(n_burst + n_single), 32'(b0 + s0));
    rdq.delete();
    xfer(0, 32'h503, 7, 0, e1);
    @(negedge clk);
    chk("R10", "stray bits one beat", 32'(rdq.size()), 1);
    if (rdq.size() > 0) chk("R10", "stray addr", rdq[0], ~32'h500 ^ 32'h5a5a_0000);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule